// File: doc/BRIEF.md
# Quiet floating-point comparator

The block compares two IEEE-754 operands and answers one of three relations: equal, greater-than or greater-or-equal. A precision select decides how the two 64-bit operand inputs are read. Either they are a pair of double-precision values, or their low 32 bits are single-precision values and the upper bits are ignored.

The comparison is quiet for every relation. When either operand is a NaN, the result is false and no exception flag is raised. This includes the ordered relations, and it includes signalling NaNs. Zeros of either sign are equal. Denormals are ordered by value like any other finite number, and infinities are ordered as the largest magnitudes.

Each comparison is launched by a one-cycle input strobe. The answer appears one clock later on a registered interface: a valid pulse, an 8-bit predicate that is all ones for true and all zeros for false, and an exception-flag vector.

Top module: `fp_quiet_cmp`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle in which `cmp_valid` was high outside reset, and low otherwise. While `rst_n` is low at a clock edge, `res_valid`, `pred` and `exc_flags` become zero, even if `cmp_valid` is high.
- R2: A true result is driven as `pred` = 0xFF and a false result as `pred` = 0x00. No other predicate value occurs.
- R3: Relation code 0 (equal) is true when both operands are ordered and have identical sign and magnitude. It is also true when both are zeros, whatever their signs.
- R4: Relation code 1 (greater-than) follows sign-magnitude order: a positive value is greater than a negative value, and of two negative values the smaller magnitude is greater. +0 and -0 are not greater than each other.
- R5: Relation code 2 (greater-or-equal) is true exactly when greater-than or equal would be true.
- R6: An operand is a NaN when its exponent field is all ones and its mantissa is non-zero. With a NaN on either side, all relations give false. An infinity (mantissa zero) is ordered above every finite value.
- R7: `exc_flags` holds invalid at bit 1, divide-by-zero at bit 2, overflow at bit 3, underflow at bit 4 and inexact at bit 5. Every bit stays zero for every comparison, including those with quiet or signalling NaN operands.
- R8: With `dbl` = 0 the operands are bits 31:0 of `opa` and `opb`, and bits 63:32 have no effect on the result. With `dbl` = 1 all 64 bits form a double.
- R9: Denormal operands are compared by value, so the smallest positive denormal is greater than zero.
- R10: Relation code 3 is reserved and always gives false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Strobe: operands and relation are valid this cycle |
| rel | input | 2 | Relation: 0 equal, 1 greater-than, 2 greater-or-equal, 3 reserved |
| dbl | input | 1 | 1: double precision, 0: single precision in bits 31:0 |
| opa | input | 64 | Left operand |
| opb | input | 64 | Right operand |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| pred | output | 8 | Predicate: 0xFF true, 0x00 false |
| exc_flags | output | 5 | Exception flags, indexed 5:1 (invalid at 1 through inexact at 5) |

## Verification
Signed zeros are compared both ways round. This separates a true sign-magnitude compare from a plain bit compare, and it shows that neither zero counts as greater. Pairs of negative values are tried in both orders to catch an unflipped magnitude compare. Quiet NaNs, signalling NaNs and infinities tell NaN detection apart from a bare all-ones exponent test, and they show that the flags stay clear on unordered inputs. Single-precision vectors carry garbage in their upper halves, and one pattern reads as a negative single but as a positive double, so the precision select is tested in both directions.

// File: rtl/fpc_pkg.sv
// Shared constants and types for the quiet floating-point comparator.
// Assumes IEEE-754 binary32 and binary64 field layouts.
package fpc_pkg;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;
    localparam int SP_W   = 1 + SP_EXP + SP_MAN;
    localparam int DP_W   = 1 + DP_EXP + DP_MAN;
    localparam int MAG_W  = DP_W - 1;
    localparam int PRED_W = 8;
    localparam int FLAG_LO = 1;
    localparam int FLAG_HI = 5;

    typedef enum logic [1:0] {
        REL_EQ  = 2'd0,
        REL_GT  = 2'd1,
        REL_GE  = 2'd2,
        REL_RSV = 2'd3
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
    } opnd_t;
endpackage

// File: rtl/fpc_unpack.sv
// Splits one operand word into sign, magnitude and a NaN marker.
// Assumes single-precision values sit in the low SP_W bits when dbl is low;
// the upper bits are then ignored. The magnitude is zero-extended.
module fpc_unpack
    import fpc_pkg::*;
(
    input  logic [DP_W-1:0] word,
    input  logic            dbl,
    output opnd_t           fields
);
    // Select field boundaries by precision and flag NaN encodings.
    always_comb begin
        if (dbl) begin
            fields.sign = word[DP_W-1];
            fields.mag  = word[MAG_W-1:0];
            fields.nan  = (&word[DP_W-2:DP_MAN]) && (|word[DP_MAN-1:0]);
        end else begin
            fields.sign = word[SP_W-1];
            fields.mag  = MAG_W'(word[SP_W-2:0]);
            fields.nan  = (&word[SP_W-2:SP_MAN]) && (|word[SP_MAN-1:0]);
        end
    end
endmodule

// File: rtl/fpc_relate.sv
// Computes the equal and greater-than relations of two unpacked operands.
// Both relations are false when either side is unordered; zeros of either
// sign are equal. Assumes magnitudes share one width for both precisions.
module fpc_relate
    import fpc_pkg::*;
(
    input  opnd_t lhs,
    input  opnd_t rhs,
    output logic  is_eq,
    output logic  is_gt
);
    logic unord;
    logic both_zero;
    logic mag_same;
    logic lhs_bigger;
    logic rhs_bigger;

    // Magnitude comparisons shared by both relations.
    always_comb begin
        unord      = lhs.nan | rhs.nan;
        both_zero  = (lhs.mag == '0) && (rhs.mag == '0);
        mag_same   = (lhs.mag == rhs.mag);
        lhs_bigger = (lhs.mag > rhs.mag);
        rhs_bigger = (lhs.mag < rhs.mag);
    end

    // Equality: same encoding, or any pair of zeros.
    always_comb begin
        is_eq = !unord && (both_zero || (mag_same && (lhs.sign == rhs.sign)));
    end

    // Greater-than in sign-magnitude order.
    always_comb begin
        if (unord || both_zero) begin
            is_gt = 1'b0;
        end else if (lhs.sign != rhs.sign) begin
            is_gt = !lhs.sign;
        end else if (!lhs.sign) begin
            is_gt = lhs_bigger;
        end else begin
            is_gt = rhs_bigger;
        end
    end
endmodule

// File: rtl/fp_quiet_cmp.sv
// Quiet IEEE-754 comparator with a registered result.
// Launches on cmp_valid; result, predicate and flags appear one clock later.
// Assumes a synchronous active-low reset. No relation raises a flag.
module fp_quiet_cmp
    import fpc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmp_valid,
    input  logic [1:0]             rel,
    input  logic                   dbl,
    input  logic [DP_W-1:0]        opa,
    input  logic [DP_W-1:0]        opb,
    output logic                   res_valid,
    output logic [PRED_W-1:0]      pred,
    output logic [FLAG_HI:FLAG_LO] exc_flags
);
    logic [DP_W-1:0] raw [2];
    opnd_t           ufld [2];
    logic            rel_eq;
    logic            rel_gt;
    logic            hit;
    rel_e            rel_sel;

    assign raw[0]  = opa;
    assign raw[1]  = opb;
    assign rel_sel = rel_e'(rel);

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_unpack
            fpc_unpack u_unpack (
                .word   (raw[g]),
                .dbl    (dbl),
                .fields (ufld[g])
            );
        end
    endgenerate

    fpc_relate u_relate (
        .lhs   (ufld[0]),
        .rhs   (ufld[1]),
        .is_eq (rel_eq),
        .is_gt (rel_gt)
    );

    // Pick the requested relation; the reserved code answers false.
    always_comb begin
        case (rel_sel)
            REL_EQ:  hit = rel_eq;
            REL_GT:  hit = rel_gt;
            REL_GE:  hit = rel_gt | rel_eq;
            default: hit = 1'b0;
        endcase
    end

    // Register the predicate, the quiet flags and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            pred      <= '0;
            exc_flags <= '0;
        end else begin
            res_valid <= cmp_valid;
            if (cmp_valid) begin
                pred      <= hit ? {PRED_W{1'b1}} : {PRED_W{1'b0}};
                exc_flags <= '0;
            end
        end
    end
endmodule

// File: rtl/fpc_checker.sv
// Property checker for fp_quiet_cmp, attached with bind below.
// Recomputes NaN status from the inputs independently of the design.
module fpc_checker
    import fpc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmp_valid,
    input logic [1:0]             rel,
    input logic                   dbl,
    input logic [DP_W-1:0]        opa,
    input logic [DP_W-1:0]        opb,
    input logic                   res_valid,
    input logic [PRED_W-1:0]      pred,
    input logic [FLAG_HI:FLAG_LO] exc_flags
);
    logic a_nan;
    logic b_nan;

    // Independent NaN view of each operand.
    always_comb begin
        if (dbl) begin
            a_nan = (opa[62:52] == 11'h7FF) && (opa[51:0] != 52'd0);
            b_nan = (opb[62:52] == 11'h7FF) && (opb[51:0] != 52'd0);
        end else begin
            a_nan = (opa[30:23] == 8'hFF) && (opa[22:0] != 23'd0);
            b_nan = (opb[30:23] == 8'hFF) && (opb[22:0] != 23'd0);
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> res_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !res_valid);
    assert_pred_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (pred == 8'h00 || pred == 8'hFF));
    assert_self_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && rel == 2'd0 && opa == opb && !a_nan) |=> pred == 8'hFF);
    assert_nan_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (a_nan || b_nan)) |=> pred == 8'h00);
    assert_flags_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> exc_flags == 5'd0);
    assert_reserved_false_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && rel == 2'd3) |=> pred == 8'h00);
endmodule

bind fp_quiet_cmp fpc_checker u_fpc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .rel       (rel),
    .dbl       (dbl),
    .opa       (opa),
    .opb       (opb),
    .res_valid (res_valid),
    .pred      (pred),
    .exc_flags (exc_flags)
);

// File: tb/test_fp_quiet_cmp.sv
`timescale 1ns/1ps
module test_fp_quiet_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  rel = 2'd0;
    logic        dbl = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        res_valid;
    logic [7:0]  pred;
    logic [5:1]  exc_flags;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_quiet_cmp i_fp_quiet_cmp (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .rel(rel), .dbl(dbl),
        .opa(opa), .opb(opb), .res_valid(res_valid), .pred(pred),
        .exc_flags(exc_flags)
    );

    // Vector: {rel[1:0], dbl, opa[63:0], opb[63:0], expect_true}
    localparam int NV = 25;
    localparam logic [131:0] VEC [NV] = '{
        {2'd0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 1'b1}, // R3
        {2'd0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, 1'b1}, // R3 +0 == -0
        {2'd1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, 1'b0}, // R4 +0 not > -0
        {2'd2, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 1'b1}, // R5
        {2'd1, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_BF80_0000, 1'b1}, // R4
        {2'd1, 1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_C000_0000, 1'b1}, // R4 -1 > -2
        {2'd1, 1'b0, 64'h0000_0000_C000_0000, 64'h0000_0000_BF80_0000, 1'b0}, // R4
        {2'd2, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 1'b0}, // R5
        {2'd1, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 1'b0}, // R6
        {2'd2, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 1'b0}, // R6
        {2'd0, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_7FC0_0000, 1'b0}, // R6
        {2'd1, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_3F80_0000, 1'b1}, // R6 inf ordered
        {2'd2, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, 1'b0}, // R6 signalling
        {2'd1, 1'b0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 1'b1}, // R9
        {2'd1, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b1}, // R9
        {2'd1, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0000, 1'b0}, // R9
        {2'd0, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 1'b1}, // R8
        {2'd1, 1'b0, 64'h7FF0_0000_0000_0000, 64'h0000_0000_3F80_0000, 1'b0}, // R8
        {2'd1, 1'b1, 64'h0000_0000_BF80_0000, 64'h0000_0000_0000_0000, 1'b1}, // R8 double denorm
        {2'd0, 1'b1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1}, // R3
        {2'd1, 1'b1, 64'h7FF8_0000_0000_0000, 64'h3F80_0000_0000_0000, 1'b0}, // R6
        {2'd2, 1'b1, 64'h7FF7_0000_0000_0000, 64'h3F80_0000_0000_0000, 1'b0}, // R6
        {2'd1, 1'b1, 64'h3F80_0000_0000_0000, 64'hBD73_1F75_0000_0000, 1'b1}, // R4
        {2'd1, 1'b1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1}, // R9
        {2'd3, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 1'b0}  // R10
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Strobe one comparison and check the registered outputs one clock later.
    task automatic run(input logic [1:0] r, input logic d, input logic [63:0] a,
                       input logic [63:0] b, input logic exp_true, input string req);
        @(negedge clk);
        rel = r; dbl = d; opa = a; opb = b; cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        check({req, " valid"}, 64'(res_valid), 64'd1);
        check({req, " pred"}, 64'(pred), exp_true ? 64'hFF : 64'h00);
        check("R7 flags", 64'(exc_flags), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(res_valid), 64'd0);
        check("R1 reset pred", 64'(pred), 64'd0);
        check("R1 reset flags", 64'(exc_flags), 64'd0);
        // Strobe during reset must be ignored.
        cmp_valid = 1'b1; rel = 2'd0; opa = 64'h3F80_0000; opb = 64'h3F80_0000;
        @(negedge clk);
        check("R1 strobe in reset", 64'(res_valid), 64'd0);
        check("R1 pred in reset", 64'(pred), 64'd0);
        cmp_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 64'(res_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][131:130], VEC[i][129], VEC[i][128:65], VEC[i][64:1], VEC[i][0],
                $sformatf("R2 vec%0d", i));
        end

        // Valid drops the cycle after the strobe ends.
        @(negedge clk);
        check("R1 valid drops", 64'(res_valid), 64'd0);

        // Greater-or-equal on equal values, then back-to-back strobes.
        run(2'd2, 1'b1, 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b1, "R5 ge equal");
        @(negedge clk);
        rel = 2'd0; dbl = 1'b0; opa = 64'h1; opb = 64'h1; cmp_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", 64'(pred), 64'hFF);
        rel = 2'd1; opa = 64'h8000_0000; opb = 64'h0;
        @(negedge clk);
        cmp_valid = 1'b0;
        check("R4 b2b second", 64'(pred), 64'h00);
        check("R1 b2b valid", 64'(res_valid), 64'd1);

        // Reset in mid-run clears outputs.
        run(2'd0, 1'b0, 64'h0, 64'h0, 1'b1, "R3 zeros");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears pred", 64'(pred), 64'd0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule